// File: doc/BRIEF.md
# Sequential 32-by-16 Divider with Signed and Unsigned Modes

This block divides a 32-bit dividend by a 16-bit divisor over several clock cycles. It develops one quotient bit per cycle with a restoring shift-subtract loop. A mode input selects between unsigned and two's-complement operation. In signed mode the block divides the magnitudes and then applies the signs. The quotient is rounded toward zero, and it is negative when the two operand signs differ. A nonzero remainder carries the sign of the dividend.

A single-cycle start strobe begins an operation. The block raises busy until a one-cycle done pulse marks the end. At done, a packed 32-bit result word holds the quotient in its low half and the remainder in its high half. The result register acts as the destination. It is written only when the division succeeds and keeps its previous value when an error is found. Two errors are reported. A zero divisor is caught at start and finishes at once. Overflow is reported when the quotient does not fit in 16 bits. Zero and negative flags describe the quotient of a successful division. The status outputs hold their values until the next done.

Top module: `div32by16_seq`

## Requirements
- R1: After reset, busy, done, div_zero, overflow, flag_zero and flag_neg are 0 and result is 0.
- R2: In unsigned mode (signed_mode=0) with a nonzero divisor and a quotient of at most 65535, result[15:0] is the quotient and result[31:16] is the remainder when done pulses; div_zero and overflow are 0.
- R3: A start accepted with divisor=0 makes done and div_zero 1 on the clock edge that accepts it; overflow, flag_zero and flag_neg are 0 and result keeps its previous value.
- R4: In unsigned mode, a quotient above 65535 sets overflow=1 and div_zero=0 at done; result keeps its previous value and flag_zero and flag_neg are 0.
- R5: In signed mode (signed_mode=1) the quotient is the two's-complement truncation toward zero of dividend/divisor, negative when the operand signs differ; a nonzero remainder has the sign of the dividend, and dividend = quotient*divisor + remainder.
- R6: In signed mode, overflow is set and result is kept when the true quotient lies outside -32768..32767; a quotient of exactly -32768 is a valid result.
- R7: A start accepted with a nonzero divisor makes busy 1 for the 16 cycles after the accepting edge; done is a one-cycle pulse set on the 16th edge after it, with busy 0 in that cycle; a start is accepted whenever busy is 0, including the done cycle.
- R8: A start while busy is 1 is ignored: the running operation finishes at its own time with the result of its own operands, and no extra done follows.
- R9: On a successful division, flag_zero = (quotient == 0) and flag_neg = quotient bit 15; div_zero, overflow and both flags hold until the next done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, taken when busy is 0 |
| signed_mode | input | 1 | 1 = two's-complement division, 0 = unsigned |
| dividend | input | 32 | Dividend, sampled at start |
| divisor | input | 16 | Divisor, sampled at start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| result | output | 32 | Remainder in [31:16], quotient in [15:0] |
| div_zero | output | 1 | Last operation had a zero divisor |
| overflow | output | 1 | Last operation's quotient did not fit |
| flag_zero | output | 1 | Quotient of last successful operation is zero |
| flag_neg | output | 1 | Quotient bit 15 of last successful operation |

## Verification
Because busy falls in the done cycle, the done pulse of one division can fall in the same cycle as the acceptance of the next start. The bench provokes this by issuing each new operation at the first falling edge where busy is low, which is the done cycle itself. Some of these back-to-back starts carry a zero divisor, so one done is followed directly by another. The scoreboard judges both operations on their own. Each must be completed on its own due cycle with its own operands. For the error case it must keep the result written by the earlier successful division.

// File: rtl/div_seq_pkg.sv
package div_seq_pkg;
    typedef enum logic {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } div_state_e;
endpackage

// File: rtl/div_prep.sv
module div_prep #(
    parameter int DVS_W = 16,
    localparam int DVD_W = 2 * DVS_W
) (
    input  logic             signed_mode,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic [DVD_W-1:0] dvd_mag,
    output logic [DVS_W-1:0] dvs_mag,
    output logic             q_neg,
    output logic             r_neg,
    output logic             dvs_zero,
    output logic             pre_ovf
);
    logic dvd_neg, dvs_neg;

    always_comb begin
        dvd_neg  = signed_mode & dividend[DVD_W-1];
        dvs_neg  = signed_mode & divisor[DVS_W-1];
        dvd_mag  = dvd_neg ? (~dividend + 1'b1) : dividend;
        dvs_mag  = dvs_neg ? (~divisor + 1'b1) : divisor;
        q_neg    = dvd_neg ^ dvs_neg;
        r_neg    = dvd_neg;
        dvs_zero = (divisor == '0);
        // quotient magnitude fits DVS_W bits only if upper half < divisor
        pre_ovf  = (dvd_mag[DVD_W-1:DVS_W] >= dvs_mag);
    end
endmodule

// File: rtl/div_step.sv
module div_step #(
    parameter int DVS_W = 16
) (
    input  logic [DVS_W-1:0] rem,
    input  logic             bit_in,
    input  logic [DVS_W-1:0] dvs,
    output logic [DVS_W-1:0] rem_nxt,
    output logic             q_bit
);
    logic [DVS_W:0] trial, diff;

    always_comb begin
        trial   = {rem, bit_in};
        diff    = trial - {1'b0, dvs};
        q_bit   = (trial >= {1'b0, dvs});
        rem_nxt = q_bit ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
    end
endmodule

// File: rtl/div_fix.sv
module div_fix #(
    parameter int DVS_W = 16,
    localparam int DVD_W = 2 * DVS_W
) (
    input  logic [DVS_W-1:0] q_mag,
    input  logic [DVS_W-1:0] r_mag,
    input  logic             q_neg,
    input  logic             r_neg,
    input  logic             sgn,
    input  logic             pre_ovf,
    output logic [DVD_W-1:0] res,
    output logic             ovf,
    output logic             fz,
    output logic             fn
);
    logic [DVS_W-1:0] q_val, r_val;
    logic             range_ovf;

    always_comb begin
        q_val     = q_neg ? (~q_mag + 1'b1) : q_mag;
        r_val     = r_neg ? (~r_mag + 1'b1) : r_mag;
        // signed: positive limit 2^(W-1)-1, negative limit 2^(W-1)
        range_ovf = sgn & q_mag[DVS_W-1] & (~q_neg | (|q_mag[DVS_W-2:0]));
        ovf       = pre_ovf | range_ovf;
        res       = {r_val, q_val};
        fz        = (q_val == '0);
        fn        = q_val[DVS_W-1];
    end
endmodule

// File: rtl/div32by16_seq.sv
module div32by16_seq
    import div_seq_pkg::*;
#(
    parameter int DVS_W = 16,
    localparam int DVD_W = 2 * DVS_W,
    localparam int CNT_W = $clog2(DVS_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             signed_mode,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [DVD_W-1:0] result,
    output logic             div_zero,
    output logic             overflow,
    output logic             flag_zero,
    output logic             flag_neg
);
    typedef struct packed {
        div_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [DVS_W-1:0] rem;
        logic [DVS_W-1:0] shr;
        logic [DVS_W-1:0] dvs;
        logic             qneg;
        logic             rneg;
        logic             sgn;
        logic             povf;
        logic             done;
        logic             dz;
        logic             ovf;
        logic             fz;
        logic             fn;
        logic [DVD_W-1:0] res;
    } regs_t;

    regs_t r_q, r_d;

    logic [DVD_W-1:0] p_dvd_mag;
    logic [DVS_W-1:0] p_dvs_mag, s_rem_nxt, s_shr_nxt;
    logic             p_qneg, p_rneg, p_zero, p_povf, s_qbit;
    logic [DVD_W-1:0] f_res;
    logic             f_ovf, f_fz, f_fn;

    div_prep #(.DVS_W(DVS_W)) u_prep (
        .signed_mode(signed_mode), .dividend(dividend), .divisor(divisor),
        .dvd_mag(p_dvd_mag), .dvs_mag(p_dvs_mag), .q_neg(p_qneg),
        .r_neg(p_rneg), .dvs_zero(p_zero), .pre_ovf(p_povf)
    );

    div_step #(.DVS_W(DVS_W)) u_step (
        .rem(r_q.rem), .bit_in(r_q.shr[DVS_W-1]), .dvs(r_q.dvs),
        .rem_nxt(s_rem_nxt), .q_bit(s_qbit)
    );

    assign s_shr_nxt = {r_q.shr[DVS_W-2:0], s_qbit};

    div_fix #(.DVS_W(DVS_W)) u_fix (
        .q_mag(s_shr_nxt), .r_mag(s_rem_nxt), .q_neg(r_q.qneg),
        .r_neg(r_q.rneg), .sgn(r_q.sgn), .pre_ovf(r_q.povf),
        .res(f_res), .ovf(f_ovf), .fz(f_fz), .fn(f_fn)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    if (p_zero) begin
                        r_d.done = 1'b1;
                        r_d.dz   = 1'b1;
                        r_d.ovf  = 1'b0;
                        r_d.fz   = 1'b0;
                        r_d.fn   = 1'b0;
                    end else begin
                        r_d.st   = S_RUN;
                        r_d.cnt  = CNT_W'(DVS_W);
                        r_d.rem  = p_dvd_mag[DVD_W-1:DVS_W];
                        r_d.shr  = p_dvd_mag[DVS_W-1:0];
                        r_d.dvs  = p_dvs_mag;
                        r_d.qneg = p_qneg;
                        r_d.rneg = p_rneg;
                        r_d.sgn  = signed_mode;
                        r_d.povf = p_povf;
                    end
                end
            end
            S_RUN: begin
                r_d.rem = s_rem_nxt;
                r_d.shr = s_shr_nxt;
                r_d.cnt = r_q.cnt - 1'b1;
                if (r_q.cnt == CNT_W'(1)) begin
                    r_d.st   = S_IDLE;
                    r_d.done = 1'b1;
                    r_d.dz   = 1'b0;
                    r_d.ovf  = f_ovf;
                    r_d.fz   = f_ovf ? 1'b0 : f_fz;
                    r_d.fn   = f_ovf ? 1'b0 : f_fn;
                    if (!f_ovf) r_d.res = f_res;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy      = (r_q.st == S_RUN);
    assign done      = r_q.done;
    assign result    = r_q.res;
    assign div_zero  = r_q.dz;
    assign overflow  = r_q.ovf;
    assign flag_zero = r_q.fz;
    assign flag_neg  = r_q.fn;

    assert_div0_fast_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && divisor == '0) |=> (done && div_zero && !overflow));

    assert_err_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (div_zero || overflow)) |-> $stable(result));

    assert_flags_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (div_zero || overflow) |-> !(flag_zero || flag_neg));

    assert_busy_no_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && divisor != '0) |=> (busy && !done));

    assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (r_q.dvs == $past(r_q.dvs) && r_q.sgn == $past(r_q.sgn)));

    assert_rem_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !r_q.povf) |-> (r_q.rem < r_q.dvs));

    assert_rem_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero && !overflow && r_q.sgn && result[DVD_W-1:DVS_W] != '0)
        |-> (result[DVD_W-1] == r_q.rneg));
endmodule

// File: tb/div32by16_seq_tb.sv
module div32by16_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        signed_mode = 1'b0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic        busy, done, div_zero, overflow, flag_zero, flag_neg;
    logic [31:0] result;

    div32by16_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
        .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
        .result(result), .div_zero(div_zero), .overflow(overflow),
        .flag_zero(flag_zero), .flag_neg(flag_neg)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [31:0] res;
        logic        dz;
        logic        ovf;
        logic        fz;
        logic        fn;
        int          due;
        string       req;
    } exp_t;

    exp_t        sb[$];
    int          errors = 0;
    int          checks = 0;
    int          cyc = 0;
    logic [31:0] model_res = '0;
    int unsigned lcg = 32'h1234_5678;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_op(input bit sm, input logic [31:0] a,
                           input logic [15:0] d, input string req);
        exp_t   e;
        longint q, r;
        bit     bad;
        e.req = req;
        e.dz = 1'b0; e.ovf = 1'b0; e.fz = 1'b0; e.fn = 1'b0;
        if (d == 16'h0) begin
            e.dz = 1'b1;
        end else begin
            if (sm) begin
                q = longint'($signed(a)) / longint'($signed(d));
                r = longint'($signed(a)) % longint'($signed(d));
                bad = (q > 32767) || (q < -32768);
            end else begin
                q = longint'(a) / longint'(d);
                r = longint'(a) % longint'(d);
                bad = (q > 65535);
            end
            if (bad) e.ovf = 1'b1;
            else begin
                model_res = {r[15:0], q[15:0]};
                e.fz = (q[15:0] == 16'h0);
                e.fn = q[15];
            end
        end
        e.res = model_res;
        @(negedge clk);
        while (busy) @(negedge clk);
        start = 1'b1; signed_mode = sm; dividend = a; divisor = d;
        e.due = (d == 16'h0) ? cyc + 1 : cyc + 17;
        sb.push_back(e);
        @(negedge clk);
        start = 1'b0;
    endtask

    always @(negedge clk) begin
        exp_t e;
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R8", "unexpected done", 1, 0);
            end else begin
                e = sb.pop_front();
                check(result === e.res, e.req, "result", result, e.res);
                check(div_zero === e.dz, e.req, "div_zero", div_zero, e.dz);
                check(overflow === e.ovf, e.req, "overflow", overflow, e.ovf);
                check({flag_zero, flag_neg} === {e.fz, e.fn}, "R9", "flags",
                      {flag_zero, flag_neg}, {e.fz, e.fn});
                check(cyc == e.due, "R7", "done cycle", cyc, e.due);
                check(!busy, "R7", "busy at done", busy, 0);
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        check(1'b0, "R7", "watchdog expired", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, done, div_zero, overflow, flag_zero, flag_neg} == 6'b0,
              "R1", "status after reset",
              {busy, done, div_zero, overflow, flag_zero, flag_neg}, 0);
        check(result == 32'h0, "R1", "result after reset", result, 0);

        push_op(1'b0, 32'd100, 16'd7, "R2");
        push_op(1'b0, 32'hFFFE_FFFF, 16'hFFFF, "R2");
        push_op(1'b0, 32'd5, 16'd9, "R2");
        push_op(1'b0, 32'hFFFF_FFFF, 16'hFFFF, "R4");
        push_op(1'b0, 32'h0001_0000, 16'h0001, "R4");
        push_op(1'b0, 32'd77, 16'd0, "R3");
        push_op(1'b1, 32'hFFFF_FF00, 16'd0, "R3");
        push_op(1'b1, -32'sd7, 16'sd2, "R5");
        push_op(1'b1, 32'sd7, -16'sd2, "R5");
        push_op(1'b1, -32'sd7, -16'sd2, "R5");
        push_op(1'b1, 32'sd0, 16'sd5, "R5");
        push_op(1'b1, -32'sd100000, 16'sd7, "R5");
        push_op(1'b1, 32'sd32768, 16'sd1, "R6");
        push_op(1'b1, -32'sd32768, 16'sd1, "R6");
        push_op(1'b1, -32'sd65536, 16'sd2, "R6");
        push_op(1'b1, 32'h8000_0000, 16'hFFFF, "R6");
        push_op(1'b1, -32'sd32769, 16'sd1, "R6");
        push_op(1'b0, 32'h0000_8000, 16'h0001, "R2");

        push_op(1'b0, 32'd1000, 16'd3, "R8");
        repeat (3) @(negedge clk);
        check(busy, "R7", "busy mid-operation", busy, 1);
        start = 1'b1; signed_mode = 1'b1; dividend = 32'd9; divisor = 16'd0;
        @(negedge clk);
        start = 1'b0;
        push_op(1'b1, 32'd1234, 16'd0, "R3");

        for (int i = 0; i < 24; i++) begin
            logic [31:0] a;
            logic [15:0] d;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            a = lcg;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            d = lcg[31:16];
            if (i % 3 == 0) a = {8'h00, a[23:0]};
            push_op(i[0], a, d, i[0] ? "R5" : "R2");
        end

        while (sb.size() != 0 || busy) @(negedge clk);
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R8", "scoreboard drained", sb.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule